// File: doc/BRIEF.md
# I2C Master Frame Writer

This block is the write side of an I2C master. Each request sends one 8-bit frame, which may be an address byte or a data byte, over an open-drain SCL/SDA pair. Two flags given with the request decide whether a START condition comes before the byte and whether a STOP condition follows the acknowledge slot. A controller can therefore build a multi-byte write transaction one frame at a time. The first frame carries START, the middle frames carry neither condition, and the last frame carries STOP. A START on a frame sent while the bus is still held open produces a repeated START.

Bus timing comes from a tick enable, for example a 1 MHz strobe derived from a 100 MHz system clock. Every bus phase (SCL low or SCL high, and each step of START or STOP) lasts one tick interval. After the eighth bit the master releases SDA for a ninth clock. It records the slave's acknowledge, raises a one-cycle completion pulse and returns to idle. While a transaction is open between frames, SCL is parked low. After a STOP, both lines are released high.

SDA is described by a level (`sda_o`) and a drive enable (`sda_oe`). The pad pulls the line low only when the enable is set and the level is 0. Otherwise the line is left to the pull-up.

Top module: `i2c_frame_tx`

## Requirements
- R1: After reset the block is idle: `scl_o`=1, `sda_oe`=0, `busy`=0, `done`=0, `ack_ok`=0. Whenever `busy`=0, `sda_oe`=0.
- R2: With `with_start`=1 the SDA line falls exactly once while SCL stays high, before the first data bit. With `with_start`=0 no such fall occurs.
- R3: The eight bits of `frame_byte` appear MSB first, one per SCL rising edge. SDA does not change while SCL is high during a bit.
- R4: On the ninth SCL clock the master releases SDA. `ack_ok` is updated to the inverse of `sda_i` sampled during that high phase, and it holds that value until the next frame's ninth clock.
- R5: With `with_stop`=1 the SDA line rises while SCL stays high after the acknowledge, and the frame ends with SCL=1 and SDA released. With `with_stop`=0 the frame ends with SCL=0 and SDA released.
- R6: `done` pulses for exactly one clock cycle per frame, in the first cycle in which `busy` is 0 again.
- R7: `req` is taken only while idle. A request during a frame changes neither the bits sent nor the frame count.
- R8: States advance only on cycles with `tick`=1. A frame occupies (3 if START) + 16 + 2 + (2 if STOP) tick intervals, so the total SCL rising edges are 9, plus 1 with STOP, counted after the START condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | Bus phase enable, one pulse per phase interval |
| req | input | 1 | Frame request strobe, taken while idle |
| frame_byte | input | 8 | Byte to send, MSB first |
| with_start | input | 1 | Precede the byte with a START condition |
| with_stop | input | 1 | Follow the acknowledge with a STOP condition |
| sda_i | input | 1 | Sampled SDA line level |
| scl_o | output | 1 | SCL level |
| sda_o | output | 1 | SDA level to drive (0 pulls low) |
| sda_oe | output | 1 | SDA drive enable |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at frame end |
| ack_ok | output | 1 | Slave acknowledged the last frame |

## Verification
The bench sweeps all 256 byte values against all four START/STOP flag combinations, with the acknowledge given or withheld, and decodes the bus itself from the line levels. A shift order bug would scramble decoded bytes. Flags handled wrongly would add or miss a START or STOP edge, or leave SCL parked at the wrong level. A slip in the bit counter would show up as a wrong number of SCL rising edges and a wrong frame length in tick intervals. An acknowledge sampled on the wrong clock or with the wrong polarity would flip `ack_ok`. Requests injected in mid-frame catch a design that restarts, reloads or queues a second frame.

// File: rtl/i2c_ftx_pkg.sv
package i2c_ftx_pkg;
  typedef enum logic [3:0] {
    PH_IDLE,
    PH_PRE_START,
    PH_START,
    PH_AFTER_START,
    PH_BIT_LO,
    PH_BIT_HI,
    PH_ACK_LO,
    PH_ACK_HI,
    PH_PRE_STOP,
    PH_STOP
  } phase_e;
endpackage

// File: rtl/i2c_ftx_seq.sv
// Phase sequencer: one bus phase per tick interval.
module i2c_ftx_seq
  import i2c_ftx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   accept,
  input  logic   with_start,
  input  logic   with_stop,
  input  logic   last_bit,
  output phase_e phase,
  output logic   frame_end
);
  phase_e phase_d;
  logic   stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stop_q <= 1'b0;
    else if (accept) stop_q <= with_stop;
  end

  always_comb begin
    phase_d = phase;
    if (phase == PH_IDLE) begin
      if (accept) phase_d = with_start ? PH_PRE_START : PH_BIT_LO;
    end else if (tick) begin
      case (phase)
        PH_PRE_START:   phase_d = PH_START;
        PH_START:       phase_d = PH_AFTER_START;
        PH_AFTER_START: phase_d = PH_BIT_LO;
        PH_BIT_LO:      phase_d = PH_BIT_HI;
        PH_BIT_HI:      phase_d = last_bit ? PH_ACK_LO : PH_BIT_LO;
        PH_ACK_LO:      phase_d = PH_ACK_HI;
        PH_ACK_HI:      phase_d = stop_q ? PH_PRE_STOP : PH_IDLE;
        PH_PRE_STOP:    phase_d = PH_STOP;
        PH_STOP:        phase_d = PH_IDLE;
        default:        phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_d;
  end

  assign frame_end = tick && ((phase == PH_ACK_HI && !stop_q) || phase == PH_STOP);
endmodule

// File: rtl/i2c_ftx_shift.sv
// Byte holder and bit pointer, MSB first.
module i2c_ftx_shift
  import i2c_ftx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              accept,
  input  logic [DATA_W-1:0] load_byte,
  input  phase_e            phase,
  output logic              cur_bit,
  output logic              last_bit
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] byte_q;
  logic [CNT_W-1:0]  idx_q;
  logic [CNT_W-1:0]  idx_d;
  logic              step_en;

  assign step_en = tick && (phase == PH_BIT_HI) && !last_bit;

  always_comb begin
    idx_d = idx_q;
    if (accept)       idx_d = TOP_IDX;
    else if (step_en) idx_d = idx_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      idx_q  <= TOP_IDX;
    end else begin
      if (accept) byte_q <= load_byte;
      idx_q <= idx_d;
    end
  end

  assign cur_bit  = byte_q[idx_q];
  assign last_bit = (idx_q == '0);
endmodule

// File: rtl/i2c_ftx_pins.sv
// Line level decode and the held-open flag between frames.
module i2c_ftx_pins
  import i2c_ftx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   frame_end,
  input  phase_e phase,
  input  logic   cur_bit,
  output logic   scl_o,
  output logic   sda_o,
  output logic   sda_oe
);
  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         open_q <= 1'b0;
    else if (frame_end) open_q <= (phase == PH_ACK_HI);
  end

  always_comb begin
    scl_o  = 1'b1;
    sda_o  = 1'b1;
    sda_oe = 1'b1;
    case (phase)
      PH_IDLE:        begin scl_o = !open_q; sda_oe = 1'b0; end
      PH_PRE_START:   begin scl_o = 1'b1; sda_o = 1'b1; end
      PH_START:       begin scl_o = 1'b1; sda_o = 1'b0; end
      PH_AFTER_START: begin scl_o = 1'b0; sda_o = 1'b0; end
      PH_BIT_LO:      begin scl_o = 1'b0; sda_o = cur_bit; end
      PH_BIT_HI:      begin scl_o = 1'b1; sda_o = cur_bit; end
      PH_ACK_LO:      begin scl_o = 1'b0; sda_oe = 1'b0; end
      PH_ACK_HI:      begin scl_o = 1'b1; sda_oe = 1'b0; end
      PH_PRE_STOP:    begin scl_o = 1'b0; sda_o = 1'b0; end
      PH_STOP:        begin scl_o = 1'b1; sda_o = 1'b0; end
      default:        begin scl_o = 1'b1; sda_oe = 1'b0; end
    endcase
  end
endmodule

// File: rtl/i2c_ftx_ack.sv
// Acknowledge capture and completion pulse.
module i2c_ftx_ack
  import i2c_ftx_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tick,
  input  logic   frame_end,
  input  phase_e phase,
  input  logic   sda_i,
  output logic   ack_ok,
  output logic   done
);
  logic sample_en;
  assign sample_en = tick && (phase == PH_ACK_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_ok <= 1'b0;
      done   <= 1'b0;
    end else begin
      if (sample_en) ack_ok <= !sda_i;
      done <= frame_end;
    end
  end
endmodule

// File: rtl/i2c_frame_tx.sv
module i2c_frame_tx
  import i2c_ftx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req,
  input  logic [DATA_W-1:0] frame_byte,
  input  logic              with_start,
  input  logic              with_stop,
  input  logic              sda_i,
  output logic              scl_o,
  output logic              sda_o,
  output logic              sda_oe,
  output logic              busy,
  output logic              done,
  output logic              ack_ok
);
  phase_e phase_q;
  logic   accept;
  logic   frame_end;
  logic   cur_bit;
  logic   last_bit;

  assign busy   = (phase_q != PH_IDLE);
  assign accept = req && !busy;

  i2c_ftx_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .accept(accept),
    .with_start(with_start), .with_stop(with_stop), .last_bit(last_bit),
    .phase(phase_q), .frame_end(frame_end)
  );

  i2c_ftx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .accept(accept),
    .load_byte(frame_byte), .phase(phase_q),
    .cur_bit(cur_bit), .last_bit(last_bit)
  );

  i2c_ftx_pins u_pins (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .phase(phase_q),
    .cur_bit(cur_bit), .scl_o(scl_o), .sda_o(sda_o), .sda_oe(sda_oe)
  );

  i2c_ftx_ack u_ack (
    .clk(clk), .rst_n(rst_n), .tick(tick), .frame_end(frame_end),
    .phase(phase_q), .sda_i(sda_i), .ack_ok(ack_ok), .done(done)
  );
endmodule

// File: rtl/i2c_frame_tx_chk.sv
module i2c_frame_tx_chk
  import i2c_ftx_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   tick,
  input logic   scl_o,
  input logic   sda_o,
  input logic   sda_oe,
  input logic   busy,
  input logic   done,
  input logic   ack_ok,
  input phase_e phase_q
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sda_oe);

  assert_ack_from_ninth_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack_ok) |-> $past(phase_q) == PH_ACK_HI);

  assert_stop_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_q) == PH_STOP) && !busy |-> scl_o && !sda_oe);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  assert_tick_paced_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && busy && !$past(tick) |-> $stable(scl_o) && $stable(sda_o) && $stable(sda_oe));
endmodule

bind i2c_frame_tx i2c_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .scl_o(scl_o), .sda_o(sda_o),
  .sda_oe(sda_oe), .busy(busy), .done(done), .ack_ok(ack_ok), .phase_q(phase_q)
);

// File: tb/i2c_frame_tx_bench.sv
`timescale 1ns/1ps
module i2c_frame_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       req = 1'b0;
  logic [7:0] frame_byte = 8'h00;
  logic       with_start = 1'b0;
  logic       with_stop = 1'b0;
  logic       sda_i;
  logic       scl_o, sda_o, sda_oe, busy, done, ack_ok;

  int n_checks = 0;
  int n_fail = 0;
  logic ack_mode = 1'b0;
  logic sda_line;

  always #10 clk = ~clk;

  // Open-drain line with pull-up; slave answers during master release.
  assign sda_line = !((sda_oe && !sda_o) || (ack_mode && busy && !sda_oe));
  assign sda_i = sda_line;

  i2c_frame_tx u_i2c_frame_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req(req), .frame_byte(frame_byte),
    .with_start(with_start), .with_stop(with_stop), .sda_i(sda_i),
    .scl_o(scl_o), .sda_o(sda_o), .sda_oe(sda_oe), .busy(busy),
    .done(done), .ack_ok(ack_ok)
  );

  always @(negedge clk) tick <= rst_n ? ~tick : 1'b0;

  // Bus monitor
  logic       p_scl = 1'b1, p_sda = 1'b1;
  int         rises, starts, stops, dones, busy_cyc;
  logic [7:0] got_byte;
  logic       ack_line;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_scl && scl_o && p_sda && !sda_line) begin
        starts++; rises = 0; got_byte = 8'h00;
      end
      if (p_scl && scl_o && !p_sda && sda_line) stops++;
      if (!p_scl && scl_o) begin
        if (rises < 8) got_byte = {got_byte[6:0], sda_line};
        else if (rises == 8) ack_line = sda_line;
        rises++;
      end
      if (done) dones++;
      if (busy) busy_cyc++;
    end
    p_scl = scl_o;
    p_sda = sda_line;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic s, input logic p,
                      input logic am, input bit inject);
    int ph;
    @(negedge clk); #2;
    rises = 0; starts = 0; stops = 0; dones = 0; busy_cyc = 0;
    got_byte = 8'h00; ack_line = 1'b1;
    ack_mode = am;
    frame_byte = b; with_start = s; with_stop = p; req = 1'b1;
    @(negedge clk); #2;
    req = 1'b0;
    if (inject) begin
      repeat (9) @(negedge clk);
      #2; frame_byte = ~b; with_start = ~s; with_stop = ~p; req = 1'b1;
      @(negedge clk); #2; req = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (6) @(negedge clk);
    #2;
    ph = (s ? 3 : 0) + 16 + 2 + (p ? 2 : 0);
    chk(starts == (s ? 1 : 0), "R2 start count", starts, s ? 1 : 0);
    chk(got_byte == b, "R3 decoded byte", got_byte, b);
    chk(rises == 9 + (p ? 1 : 0), "R8 scl rising edges", rises, 9 + (p ? 1 : 0));
    chk(ack_line == !am, "R4 ninth-clock line", ack_line, !am);
    chk(ack_ok == am, "R4 ack_ok", ack_ok, am);
    chk(stops == (p ? 1 : 0), "R5 stop count", stops, p ? 1 : 0);
    chk(scl_o == p && !sda_oe, "R5 parked scl", scl_o, p);
    chk(dones == 1, inject ? "R7 done count with injected req" : "R6 done count", dones, 1);
    chk(busy_cyc >= 2*ph-1 && busy_cyc <= 2*ph, "R8 frame cycles", busy_cyc, 2*ph);
    if (inject) chk(!busy, "R7 no queued frame", busy, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk(scl_o == 1'b1, "R1 reset scl", scl_o, 1);
    chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(ack_ok == 1'b0, "R1 reset ack_ok", ack_ok, 0);
    for (int b = 0; b < 256; b++) begin
      for (int f = 0; f < 4; f++) begin
        send(8'(b), f[0], f[1], b[0] ^ f[0], (b % 37) == 3);
      end
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule